// File: doc/BRIEF.md
# SPI Flash Command Controller

This block lets a host processor issue one serial flash command at a time through three 32-bit registers. Software first loads a word that packs the command byte with a 24-bit flash address. It may load up to four payload bytes into the data register. It then writes the control register with a transmit count, a receive count and the start bit. The controller drives chip select, shifts the selected bytes out in SPI mode 0, and captures the response bytes back into the data register. Software polls a busy flag until the transfer is over.

A single sequencer state machine runs each transfer, with four states. IDLE waits for an accepted start. LEAD holds chip select low for one serial clock period before the first bit. SHIFT moves the bits out and in. TRAIL holds chip select low for one more period after the last bit. The transitions are as follows. IDLE goes to LEAD when a start is accepted. LEAD goes to SHIFT at the end of its period. SHIFT goes to TRAIL when bit 0 of the last byte has completed. TRAIL goes back to IDLE at the end of its period. The serial clock runs at the system clock divided by 2×HALF, and HALF defaults to 1.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: Register offsets are control 0x0, command word 0x4 and data 0x8. The command word and the data register read back what was written. Control reads back every written bit except bit 8 (start), which reads 0, and bit 16, which shows busy.
- R2: The transmit count (control bits 3:0) includes the command byte. The wire order is command bits 7:0, then address bits 31:24, 23:16 and 15:8, then data-register bytes with bits 7:0 first. Positions at or beyond the transmit count, and positions 8 and up, send 0x00. Every byte is sent most-significant bit first.
- R3: The receive bytes (count in control bits 7:4) follow the transmit bytes, with MOSI low. Receive byte j replaces data bits 8j+7:8j for j < 4. Any other data byte keeps its previous value.
- R4: Busy (control bit 16) reads 1 from the cycle after an accepted start until the trailing period ends. Chip select goes low at the start of the lead period and rises when the trailing period ends. The lead and trailing periods each last one serial clock period.
- R5: Mode 0 timing applies. SCLK is low whenever chip select is high. Each bit holds SCLK low for HALF cycles and then high for HALF cycles. MOSI does not change while SCLK is high.
- R6: A control write with start set while busy has no effect. The register contents and the running transfer are both unchanged.
- R7: A start with both counts zero starts no transfer. The other bits of that write are still stored.
- R8: A control write without start stores its bits and starts no transfer.
- R9: After reset, all registers read 0, chip select is high, and SCLK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench sends these typical commands and compares chip select, SCLK and MOSI every cycle:
- write enable, a transmit-only command
- sector erase, an address-only command
- page program with full and partial payloads
- status read and signature read, which return a response

The partial-payload and oversized counts separate correct byte selection from any off-by-one in the count. Response reads from a slave that returns a known bit pattern show whether each byte lands in the right data lane and whether the lanes above it are kept. A start written during a transfer and a start with zero counts show whether those writes are dropped or leak into the stored state.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } seq_state_t;

    localparam int CNT_W      = 4;
    localparam int OFF_CTRL   = 0;
    localparam int OFF_CMD    = 4;
    localparam int OFF_DATA   = 8;
    localparam int START_BIT  = 8;
    localparam int BUSY_BIT   = 16;
    localparam logic [31:0] KEEP_MASK = ~((32'd1 << START_BIT) | (32'd1 << BUSY_BIT));
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    output logic              go,
    output logic [CNT_W-1:0]  go_tx,
    output logic [CNT_W-1:0]  go_rx,
    output logic [31:0]       cmd_q,
    output logic [31:0]       data_q,
    input  logic              rx_we,
    input  logic [1:0]        rx_lane,
    input  logic [7:0]        rx_byte
);
    logic [31:0] ctrl_q;
    logic        wr_ctrl;
    logic        start_req;
    logic        drop;

    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign start_req = wr_ctrl && bus_wdata[START_BIT];
    assign drop      = start_req && busy;
    assign go_tx     = bus_wdata[CNT_W-1:0];
    assign go_rx     = bus_wdata[2*CNT_W-1:CNT_W];
    assign go        = start_req && !busy && ((go_tx | go_rx) != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (wr_ctrl && !drop)
                ctrl_q <= bus_wdata & KEEP_MASK;
            if (bus_wr && bus_addr == ADDR_W'(OFF_CMD))
                cmd_q <= bus_wdata;
            if (rx_we)
                data_q[{rx_lane, 3'b000} +: 8] <= rx_byte;
            else if (bus_wr && bus_addr == ADDR_W'(OFF_DATA))
                data_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            bus_rdata = ctrl_q;
            bus_rdata[BUSY_BIT] = busy;
        end else if (bus_addr == ADDR_W'(OFF_CMD)) begin
            bus_rdata = cmd_q;
        end else if (bus_addr == ADDR_W'(OFF_DATA)) begin
            bus_rdata = data_q;
        end
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int HALF = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] go_tx,
    input  logic [CNT_W-1:0] go_rx,
    input  logic [31:0]      cmd_i,
    input  logic [31:0]      data_i,
    input  logic             miso,
    output logic             busy,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    output logic             rx_we,
    output logic [1:0]       rx_lane,
    output logic [7:0]       rx_byte
);
    localparam int BYTE_W = CNT_W + 1;
    localparam int HC_W   = (HALF > 1) ? $clog2(HALF) : 1;

    seq_state_t        state_q, state_d;
    logic [HC_W-1:0]   half_cnt;
    logic              phase_q;
    logic [2:0]        bit_q;
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] last_q;
    logic [CNT_W-1:0]  txc_q;
    logic [7:0]        tx_sh;
    logic [7:0]        rx_sh;
    logic              half_done;
    logic [BYTE_W-1:0] rx_off;

    assign half_done = (half_cnt == HC_W'(HALF - 1));
    assign rx_off    = byte_q - {1'b0, txc_q};

    function automatic logic [7:0] tx_byte(input logic [BYTE_W-1:0] idx);
        logic [1:0] sel;
        sel = 2'd0 - idx[1:0];
        if (idx >= {1'b0, txc_q})
            return 8'h00;
        else if (idx == '0)
            return cmd_i[7:0];
        else if (idx < BYTE_W'(4))
            return cmd_i[{sel, 3'b000} +: 8];
        else if (idx < BYTE_W'(8))
            return data_i[{idx[1:0], 3'b000} +: 8];
        else
            return 8'h00;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = ST_LEAD;
            ST_LEAD:  if (half_done && phase_q) state_d = ST_SHIFT;
            ST_SHIFT: if (half_done && phase_q && bit_q == 3'd7 && byte_q == last_q)
                          state_d = ST_TRAIL;
            ST_TRAIL: if (half_done && phase_q) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            half_cnt <= '0;
            phase_q  <= 1'b0;
            bit_q    <= '0;
            byte_q   <= '0;
            last_q   <= '0;
            txc_q    <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_we    <= 1'b0;
            rx_lane  <= '0;
            rx_byte  <= '0;
        end else begin
            state_q <= state_d;
            rx_we   <= 1'b0;
            if (state_q == ST_IDLE) begin
                half_cnt <= '0;
                phase_q  <= 1'b0;
                if (go) begin
                    txc_q  <= go_tx;
                    last_q <= {1'b0, go_tx} + {1'b0, go_rx} - BYTE_W'(1);
                    byte_q <= '0;
                    bit_q  <= '0;
                end
            end else begin
                half_cnt <= half_done ? '0 : half_cnt + HC_W'(1);
                if (half_done) begin
                    phase_q <= ~phase_q;
                    if (state_q == ST_LEAD && phase_q)
                        tx_sh <= tx_byte('0);
                    if (state_q == ST_SHIFT && !phase_q)
                        rx_sh <= {rx_sh[6:0], miso};
                    if (state_q == ST_SHIFT && phase_q) begin
                        if (bit_q == 3'd7) begin
                            bit_q  <= '0;
                            byte_q <= byte_q + BYTE_W'(1);
                            tx_sh  <= tx_byte(byte_q + BYTE_W'(1));
                            if (byte_q >= {1'b0, txc_q} && rx_off < BYTE_W'(4)) begin
                                rx_we   <= 1'b1;
                                rx_lane <= rx_off[1:0];
                                rx_byte <= rx_sh;
                            end
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            tx_sh <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        busy = (state_q != ST_IDLE);
        cs_n = (state_q == ST_IDLE);
        sck  = (state_q == ST_SHIFT) && phase_q;
        mosi = (state_q == ST_SHIFT) ? tx_sh[7] : 1'b0;
    end
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int HALF   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic             busy;
    logic             go;
    logic [CNT_W-1:0] go_tx;
    logic [CNT_W-1:0] go_rx;
    logic [31:0]      cmd_q;
    logic [31:0]      data_q;
    logic             rx_we;
    logic [1:0]       rx_lane;
    logic [7:0]       rx_byte;

    spi_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .go(go), .go_tx(go_tx), .go_rx(go_rx), .cmd_q(cmd_q), .data_q(data_q),
        .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte)
    );

    spi_cmd_seq #(.HALF(HALF)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .go_tx(go_tx), .go_rx(go_rx),
        .cmd_i(cmd_q), .data_i(data_q), .miso(spi_miso), .busy(busy),
        .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spi_cmd_ctrl_chk.sv
module spi_cmd_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              spi_sck,
    input logic              spi_cs_n,
    input logic              spi_mosi,
    input logic              busy
);
    logic ctrl_start;
    assign ctrl_start = bus_wr && (bus_addr == '0) && bus_wdata[8];

    p_start_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_start && !busy && bus_wdata[7:0] != 8'h00) |=> (busy && !spi_cs_n));

    p_cs_before_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $past(!spi_cs_n));

    p_idle_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_sck && !spi_mosi));

    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));

    p_zero_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_start && !busy && bus_wdata[7:0] == 8'h00) |=> !busy);

    p_start_reads0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (!bus_rdata[8] && bus_rdata[16] == busy));
endmodule

bind spi_cmd_ctrl spi_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/spi_cmd_ctrl_test.sv
`timescale 1ns/1ps
module spi_cmd_ctrl_test;
    localparam int HALF = 1;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic mosi;
        logic busy;
    } pin_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    logic [31:0] miso_seed = '0;
    int          bitcnt = 0;

    pin_t        exp_q[$];
    logic [31:0] cmd_m = '0, data_m = '0, ctrl_m = '0;
    int          n_chk = 0, n_bad = 0;
    bit          started = 0, done = 0, last_busy = 0;

    always #10 clk = ~clk;

    spi_cmd_ctrl #(.ADDR_W(4), .HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always @(negedge spi_sck or posedge spi_cs_n)
        if (spi_cs_n) bitcnt <= 0;
        else          bitcnt <= bitcnt + 1;
    assign spi_miso = miso_seed[bitcnt % 32];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        pin_t e;
        if (started && !done) begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else                  e = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0, busy: 1'b0};
            chk(spi_cs_n === e.cs_n, "R4 cs_n", {31'd0, spi_cs_n}, {31'd0, e.cs_n});
            chk(spi_sck  === e.sck,  "R5 sck",  {31'd0, spi_sck},  {31'd0, e.sck});
            chk(spi_mosi === e.mosi, "R2 mosi", {31'd0, spi_mosi}, {31'd0, e.mosi});
            last_busy = e.busy;
        end
    end

    function automatic logic [7:0] wire_byte(input int b, input int tx);
        if (b >= tx || b >= 8) return 8'h00;
        case (b)
            0: return cmd_m[7:0];
            1: return cmd_m[31:24];
            2: return cmd_m[23:16];
            3: return cmd_m[15:8];
            default: return data_m[8*(b-4) +: 8];
        endcase
    endfunction

    task automatic push_frame(input int tx, input int rx);
        logic [7:0] v;
        for (int i = 0; i < 2*HALF; i++) exp_q.push_back('{1'b0, 1'b0, 1'b0, 1'b1});
        for (int b = 0; b < tx + rx; b++) begin
            v = wire_byte(b, tx);
            for (int k = 7; k >= 0; k--) begin
                for (int i = 0; i < HALF; i++) exp_q.push_back('{1'b0, 1'b0, v[k], 1'b1});
                for (int i = 0; i < HALF; i++) exp_q.push_back('{1'b0, 1'b1, v[k], 1'b1});
            end
        end
        for (int i = 0; i < 2*HALF; i++) exp_q.push_back('{1'b0, 1'b0, 1'b0, 1'b1});
        for (int j = 0; j < rx && j < 4; j++)
            for (int k = 0; k < 8; k++)
                data_m[8*j + 7 - k] = miso_seed[((tx + j)*8 + k) % 32];
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] wd);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = wd;
        if (a == 4'h0) begin
            if (!(wd[8] && last_busy)) begin
                ctrl_m = wd & ~32'h0001_0100;
                if (wd[8] && wd[7:0] != 8'h00) push_frame(int'(wd[3:0]), int'(wd[7:4]));
            end
        end else if (a == 4'h4) cmd_m = wd;
        else if (a == 4'h8)     data_m = wd;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        bus_addr = a;
        #2;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R4 actual=hung expected=idle");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        // R9 reset state
        chk({spi_cs_n, spi_sck, spi_mosi} === 3'b100, "R9 pins", {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'd4);
        started = 1;
        read_chk(4'h0, 32'h0, "R9 ctrl");
        read_chk(4'h4, 32'h0, "R9 cmd");
        read_chk(4'h8, 32'h0, "R9 data");

        // R1 readback, R8 store without start
        bus_write(4'h4, 32'h1234_56D8);
        bus_write(4'h8, 32'hCAFE_F00D);
        read_chk(4'h4, 32'h1234_56D8, "R1 cmd");
        read_chk(4'h8, 32'hCAFE_F00D, "R1 data");
        bus_write(4'h0, 32'h0A00_0034);
        repeat (6) @(negedge clk);
        read_chk(4'h0, 32'h0A00_0034, "R8 ctrl stored");

        // write enable, opcode only (R2)
        bus_write(4'h4, 32'h0000_0006);
        bus_write(4'h0, 32'h0100_0101);
        read_chk(4'h0, 32'h0101_0001, "R4 busy bit set");
        wait_idle();
        read_chk(4'h0, 32'h0100_0001, "R1 start reads 0");

        // sector erase, opcode + address (R2)
        bus_write(4'h4, 32'h1234_56D8);
        bus_write(4'h0, 32'h0000_0104);
        wait_idle();
        read_chk(4'h0, 32'h0000_0004, "R4 busy cleared");

        // page program, full and partial payload (R2)
        bus_write(4'h8, 32'h4433_2211);
        bus_write(4'h4, 32'hABCD_EF02);
        bus_write(4'h0, 32'h0000_0108);
        wait_idle();
        bus_write(4'h0, 32'h0000_0106);
        wait_idle();
        bus_write(4'h0, 32'h0000_010A);
        wait_idle();

        // read status, one response byte, upper lanes kept (R3)
        bus_write(4'h8, 32'hAABB_CCDD);
        bus_write(4'h4, 32'h0000_0005);
        miso_seed = 32'h5A3C_96E1;
        bus_write(4'h0, 32'h0000_0111);
        wait_idle();
        read_chk(4'h8, data_m, "R3 status byte");

        // read signature (R3)
        bus_write(4'h4, 32'h0000_00AB);
        miso_seed = 32'h0F1E_2D3C;
        bus_write(4'h0, 32'h0000_0114);
        wait_idle();
        read_chk(4'h8, data_m, "R3 signature");

        // four and six response bytes (R3)
        bus_write(4'h4, 32'h0010_0003);
        miso_seed = 32'h9B71_4C2E;
        bus_write(4'h0, 32'h0000_0144);
        wait_idle();
        read_chk(4'h8, data_m, "R3 four bytes");
        miso_seed = 32'h6D25_E8B3;
        bus_write(4'h0, 32'h0000_0161);
        wait_idle();
        read_chk(4'h8, data_m, "R3 six bytes");

        // start while busy is dropped (R6)
        bus_write(4'h4, 32'h0000_0006);
        bus_write(4'h0, 32'h0000_0101);
        repeat (3) @(negedge clk);
        bus_write(4'h0, 32'h0000_01F4);
        wait_idle();
        read_chk(4'h0, 32'h0000_0001, "R6 ctrl unchanged");

        // start with zero counts (R7)
        bus_write(4'h0, 32'h0000_0300);
        repeat (6) @(negedge clk);
        read_chk(4'h0, 32'h0000_0200, "R7 ctrl stored");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule